// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two single-precision binary floating-point numbers and returns their sum, rounded to the nearest representable value with ties going to the even value. Each operand is split into its sign, its biased exponent and its fraction, and the implicit leading one is put back. The operand with the smaller magnitude is shifted right until its exponent matches the larger one. Guard, round and sticky bits are kept during this shift. The two significands are then added, or subtracted when the signs differ. The result is normalized, its exponent is checked against the representable range, and it is rounded. If rounding carries out of the significand, the result is normalized once more.

Operands enter through a valid/ready handshake, and the result leaves through another one, one cycle after it is accepted. Two flags travel with each result. One reports that the exponent grew too large and the result became infinity. The other reports that the result was too small and became zero. Subnormal operands count as zero, and the block never produces a subnormal result. Any not-a-number outcome is a single fixed quiet NaN.

Top module: `fpadd_sp`

## Requirements
- R1: Fields are sign in bit 31, a biased exponent in bits 30:23 (bias 127) and a fraction in bits 22:0. For two normal operands whose sum lies in the normal range, `out_sum` is the exact sum rounded to nearest, ties to even, and both flags are 0.
- R2: Alignment keeps every bit shifted out of the smaller operand for rounding, at any exponent difference. A shifted-out part of exactly half an ulp rounds to the even neighbour, and a smaller operand below half an ulp leaves the larger operand unchanged.
- R3: When the signs differ, the result takes the sign of the operand with the larger magnitude, and the leading zeros left by cancellation are shifted out with the exponent lowered to match. Operands of equal magnitude and opposite sign give +0 (0x00000000).
- R4: A carry out of the significand addition, or out of the rounding increment, shifts the significand right by one and raises the exponent by one.
- R5: An operand whose exponent field is 0 counts as a zero of its own sign. Zero plus a number x gives x. Two zeros give -0 only when both are -0, and +0 otherwise.
- R6: When the exponent after rounding reaches 255, the result is infinity with the sum's sign (exponent 255, fraction 0) and `out_ovf` is 1.
- R7: When the normalized exponent before rounding is below 1, the result is zero with the sum's sign and `out_unf` is 1. No result has exponent field 0 and a non-zero fraction.
- R8: The result is 0x7FC00000 when either operand is a NaN (exponent 255, fraction non-zero), and also for +infinity plus -infinity. Any other sum that involves an infinity gives that infinity. In all of these cases both flags are 0.
- R9: `in_ready` equals `!out_valid || out_ready`. An operand pair accepted on a clock edge appears with `out_valid` high after that edge. The result and the flags stay unchanged while `out_valid` is high and `out_ready` is low.
- R10: While reset is asserted, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The block can take the offered pair |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result |
| out_sum | output | 32 | Rounded sum |
| out_ovf | output | 1 | Result became infinity through exponent overflow |
| out_unf | output | 1 | Result became zero through exponent underflow |

## Verification
The hardest cases to reach from the ports are rounding ties that sit exactly on a sticky boundary. One is a tie during subtraction just below a power of two, where the half-ulp step changes size. Another is a rounding carry that pushes the largest finite value into infinity. Uniform random operands almost never land on either case. The stimulus therefore includes hand-chosen pairs, such as one minus 2^-25, a fraction of all ones plus half an ulp, and the largest finite value plus half its ulp. It also mixes in random pairs whose exponents lie within two of each other and whose signs are often opposite, so that deep cancellation and results near the minimum normal exponent come up often. Every result is compared with a behavioural model: the model adds the operands in double precision, which is exact for the exponent gaps that matter, and then rounds to single precision by explicit bit arithmetic.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

   // Operand-pair classification decided before the arithmetic path.
   typedef enum logic [1:0] {
      CLS_NUM  = 2'd0,
      CLS_ZERO = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } opclass_e;

   // Guard, round and sticky bits carried below the significand.
   localparam int GRS_W = 3;

endpackage

// File: rtl/fpadd_align.sv
module fpadd_align
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int EXT_W = FRAC_W + 1 + GRS_W
) (
   input  logic [W-1:0]     op_a,
   input  logic [W-1:0]     op_b,
   output opclass_e         cls,
   output logic             cls_sign,
   output logic             res_sign,
   output logic             eff_sub,
   output logic [EXP_W-1:0] big_exp,
   output logic [EXT_W-1:0] big_sig,
   output logic [EXT_W-1:0] small_sig
);

   localparam logic [EXP_W-1:0] EXP_ONES = '1;
   localparam logic [EXT_W-1:0] EXT_ONES = '1;

   if (FRAC_W < 2) begin : g_bad_frac
      $error("fpadd_align: FRAC_W must be at least 2");
   end

   logic             sa, sb;
   logic [EXP_W-1:0] ea, eb;
   logic [FRAC_W-1:0] fa, fb;
   assign {sa, ea, fa} = op_a;
   assign {sb, eb, fb} = op_b;

   logic za, zb, ia, ib, na, nb;
   assign za = (ea == '0);
   assign zb = (eb == '0);
   assign ia = (ea == EXP_ONES) && (fa == '0);
   assign ib = (eb == EXP_ONES) && (fb == '0);
   assign na = (ea == EXP_ONES) && (fa != '0);
   assign nb = (eb == EXP_ONES) && (fb != '0);

   // Special-operand classification
   always_comb begin
      cls      = CLS_NUM;
      cls_sign = 1'b0;
      if (na || nb || (ia && ib && (sa != sb))) begin
         cls = CLS_NAN;
      end else if (ia) begin
         cls      = CLS_INF;
         cls_sign = sa;
      end else if (ib) begin
         cls      = CLS_INF;
         cls_sign = sb;
      end else if (za && zb) begin
         cls      = CLS_ZERO;
         cls_sign = sa & sb;
      end
   end

   // Magnitude compare on flushed operands, then swap
   logic [EXP_W+FRAC_W-1:0] mag_a, mag_b;
   logic [EXT_W-1:0]        sig_a, sig_b, sm_raw;
   logic [EXP_W-1:0]        sm_exp, diff;
   logic                    a_big;

   assign mag_a = za ? '0 : {ea, fa};
   assign mag_b = zb ? '0 : {eb, fb};
   assign sig_a = za ? '0 : {1'b1, fa, {GRS_W{1'b0}}};
   assign sig_b = zb ? '0 : {1'b1, fb, {GRS_W{1'b0}}};
   assign a_big = (mag_a >= mag_b);

   assign res_sign = a_big ? sa : sb;
   assign big_exp  = a_big ? ea : eb;
   assign big_sig  = a_big ? sig_a : sig_b;
   assign sm_exp   = a_big ? eb : ea;
   assign sm_raw   = a_big ? sig_b : sig_a;
   assign diff     = big_exp - sm_exp;
   assign eff_sub  = sa ^ sb;

   // Step 1: right shift with sticky collection of every lost bit
   logic [EXT_W-1:0] shifted;
   logic             lost;
   assign shifted   = sm_raw >> diff;
   assign lost      = |(sm_raw & ~(EXT_ONES << diff));
   assign small_sig = {shifted[EXT_W-1:1], shifted[0] | lost};

endmodule

// File: rtl/fpadd_addnorm.sv
module fpadd_addnorm
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int EXT_W = FRAC_W + 1 + GRS_W,
   localparam int XE_W  = EXP_W + 2
) (
   input  logic [EXP_W-1:0]        big_exp,
   input  logic [EXT_W-1:0]        big_sig,
   input  logic [EXT_W-1:0]        small_sig,
   input  logic                    eff_sub,
   output logic [EXT_W-2:0]        norm_frac,
   output logic signed [XE_W-1:0]  norm_exp,
   output logic                    cancel,
   output logic                    below
);

   localparam int SUM_W = EXT_W + 1;
   localparam int LZ_W  = $clog2(EXT_W + 1);

   if ((1 << (XE_W - 1)) <= (1 << EXP_W) + EXT_W) begin : g_bad_xe
      $error("fpadd_addnorm: internal exponent too narrow");
   end

   // Step 2: significand add or subtract (big >= small in magnitude)
   logic [SUM_W-1:0] sum;
   assign sum = eff_sub ? ({1'b0, big_sig} - {1'b0, small_sig})
                        : ({1'b0, big_sig} + {1'b0, small_sig});

   // Leading-zero count over the in-range part of the sum
   logic [LZ_W-1:0] lz;
   always_comb begin
      logic found;
      found = 1'b0;
      lz    = '0;
      for (int i = EXT_W - 1; i >= 0; i--) begin
         if (!found && sum[i]) begin
            lz    = LZ_W'(EXT_W - 1 - i);
            found = 1'b1;
         end
      end
   end

   // Step 3: normalize and adjust the exponent
   logic [EXT_W-1:0] norm;
   always_comb begin
      if (sum[SUM_W-1]) begin
         norm     = {sum[SUM_W-1:2], |sum[1:0]};
         norm_exp = XE_W'(big_exp) + XE_W'(1);
      end else begin
         norm     = sum[EXT_W-1:0] << lz;
         norm_exp = XE_W'(big_exp) - XE_W'(lz);
      end
   end

   assign cancel    = ~norm[EXT_W-1];
   assign norm_frac = norm[EXT_W-2:0];
   assign below     = ~cancel && (norm_exp < $signed(XE_W'(1)));

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int XE_W  = EXP_W + 2
) (
   input  opclass_e                       cls,
   input  logic                           cls_sign,
   input  logic                           res_sign,
   input  logic [FRAC_W+GRS_W-1:0]        norm_frac,
   input  logic signed [XE_W-1:0]         norm_exp,
   input  logic                           cancel,
   input  logic                           below,
   output logic [W-1:0]                   result,
   output logic                           ovf,
   output logic                           unf
);

   localparam logic [EXP_W-1:0]       EXP_ONES = '1;
   localparam logic signed [XE_W-1:0] EXP_TOP  = XE_W'((1 << EXP_W) - 1);
   localparam logic [W-1:0]           QNAN     =
      {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

   // Step 4: round to nearest even on guard/round/sticky
   logic [FRAC_W-1:0] frac, frac_r;
   logic              g, r, s, up, fcarry;
   logic signed [XE_W-1:0] exp_r;

   assign frac = norm_frac[FRAC_W+GRS_W-1:GRS_W];
   assign g    = norm_frac[GRS_W-1];
   assign r    = norm_frac[GRS_W-2];
   assign s    = norm_frac[GRS_W-3];
   assign up   = g & (r | s | frac[0]);
   assign {fcarry, frac_r} = {1'b0, frac} + (FRAC_W+1)'(up);
   // a carry leaves 10.000..., renormalized by bumping the exponent
   assign exp_r = norm_exp + $signed({{(XE_W-1){1'b0}}, fcarry});

   always_comb begin
      ovf    = 1'b0;
      unf    = 1'b0;
      result = '0;
      unique case (cls)
         CLS_NAN:  result = QNAN;
         CLS_INF:  result = {cls_sign, EXP_ONES, {FRAC_W{1'b0}}};
         CLS_ZERO: result = {cls_sign, {(W-1){1'b0}}};
         default: begin
            if (cancel) begin
               result = '0;
            end else if (below) begin
               unf    = 1'b1;
               result = {res_sign, {(W-1){1'b0}}};
            end else if (exp_r >= EXP_TOP) begin
               ovf    = 1'b1;
               result = {res_sign, EXP_ONES, {FRAC_W{1'b0}}};
            end else begin
               result = {res_sign, exp_r[EXP_W-1:0], frac_r};
            end
         end
      endcase
   end

endmodule

// File: rtl/fpadd_sp.sv
module fpadd_sp
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int EXT_W = FRAC_W + 1 + GRS_W,
   localparam int XE_W  = EXP_W + 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_sum,
   output logic         out_ovf,
   output logic         out_unf
);

   if (EXP_W < 3) begin : g_bad_exp
      $error("fpadd_sp: EXP_W must be at least 3");
   end

   opclass_e               cls;
   logic                   cls_sign, res_sign, eff_sub, cancel, below;
   logic [EXP_W-1:0]       big_exp;
   logic [EXT_W-1:0]       big_sig, small_sig;
   logic [EXT_W-2:0]       norm_frac;
   logic signed [XE_W-1:0] norm_exp;
   logic [W-1:0]           sum_c;
   logic                   ovf_c, unf_c;

   fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .op_a(in_a), .op_b(in_b), .cls(cls), .cls_sign(cls_sign),
      .res_sign(res_sign), .eff_sub(eff_sub), .big_exp(big_exp),
      .big_sig(big_sig), .small_sig(small_sig)
   );

   fpadd_addnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addnorm (
      .big_exp(big_exp), .big_sig(big_sig), .small_sig(small_sig),
      .eff_sub(eff_sub), .norm_frac(norm_frac), .norm_exp(norm_exp),
      .cancel(cancel), .below(below)
   );

   fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
      .cls(cls), .cls_sign(cls_sign), .res_sign(res_sign),
      .norm_frac(norm_frac), .norm_exp(norm_exp), .cancel(cancel),
      .below(below), .result(sum_c), .ovf(ovf_c), .unf(unf_c)
   );

   // Single result register with valid/ready on both sides
   logic accept;
   assign in_ready = ~out_valid | out_ready;
   assign accept   = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sum   <= '0;
         out_ovf   <= 1'b0;
         out_unf   <= 1'b0;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_sum   <= sum_c;
         out_ovf   <= ovf_c;
         out_unf   <= unf_c;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R9: accepted pair produces a held result next cycle
   a_r9_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   // R9: stalled result does not change
   a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_sum)
                                  && $stable(out_ovf) && $stable(out_unf));

   // R6: overflow flag pairs with an infinity encoding
   a_r6_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ovf |-> out_sum[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

   // R7: underflow flag pairs with a zero encoding
   a_r7_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_unf |-> out_sum[W-2:0] == '0);

   // R7: never a subnormal result
   a_r7_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sum[W-2:FRAC_W] == '0 |-> out_sum[FRAC_W-1:0] == '0);

   // R6/R7: the two range flags never coincide
   a_r6_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_ovf && out_unf));

endmodule

// File: tb/fpadd_sp_test.sv
module fpadd_sp_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_sum;
   logic        out_ovf, out_unf;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [33:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   fpadd_sp uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
      .out_sum(out_sum), .out_ovf(out_ovf), .out_unf(out_unf)
   );

   // ---------------- behavioural reference ----------------
   function automatic logic [63:0] to_dbl(input logic [31:0] x);
      int ed;
      if (x[30:23] == 8'd0) return {x[31], 63'd0};
      ed = int'(x[30:23]) + 896;
      return {x[31], ed[10:0], x[22:0], 29'd0};
   endfunction

   // returns {ovf, unf, result}
   function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b);
      logic [63:0] d;
      logic [23:0] f24;
      logic        up;
      real         s;
      int          e;
      bit na, nb, ia, ib;
      na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      ia = (a[30:23] == 8'hFF) && (a[22:0] == 0);
      ib = (b[30:23] == 8'hFF) && (b[22:0] == 0);
      if (na || nb || (ia && ib && a[31] != b[31])) return {2'b00, 32'h7FC00000};
      if (ia) return {2'b00, a};
      if (ib) return {2'b00, b};
      s = $bitstoreal(to_dbl(a)) + $bitstoreal(to_dbl(b));
      d = $realtobits(s);
      if (d[62:0] == 0) return {2'b00, d[63], 31'd0};
      e = int'(d[62:52]) - 896;
      if (e < 1) return {2'b01, d[63], 31'd0};
      up  = d[28] && ((d[27:0] != 0) || d[29]);
      f24 = {1'b0, d[51:29]} + {23'd0, up};
      if (f24[23]) e = e + 1;
      if (e >= 255) return {2'b10, d[63], 8'hFF, 23'd0};
      return {2'b00, d[63], e[7:0], f24[22:0]};
   endfunction

   // ---------------- checking helpers ----------------
   task automatic check_bit(input string req, input logic act, input logic expv, input string what);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, expv);
      end
   endtask

   task automatic check_outputs();
      check_bit("R9", out_valid, logic'(exp_q.size() != 0), "out_valid");
      if (out_valid && exp_q.size() != 0) begin
         checks++;
         if ({out_ovf, out_unf, out_sum} !== exp_q[0]) begin
            fails++;
            $display("FAIL %s result: actual ovf=%0b unf=%0b sum=%08h expected ovf=%0b unf=%0b sum=%08h",
                     tag_q[0], out_ovf, out_unf, out_sum,
                     exp_q[0][33], exp_q[0][32], exp_q[0][31:0]);
         end
      end
   endtask

   // one cycle: check, drive, update the model
   task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                       input string tg, input bit rdy, output bit acc);
      bit model_ready, fire;
      @(negedge clk);
      check_outputs();
      in_valid  = v;
      in_a      = a;
      in_b      = b;
      out_ready = rdy;
      #1;
      model_ready = (exp_q.size() == 0) || rdy;
      check_bit("R9", in_ready, logic'(model_ready), "in_ready");
      fire = (exp_q.size() != 0) && rdy;
      acc  = v && model_ready;
      if (fire) begin
         void'(exp_q.pop_front());
         void'(tag_q.pop_front());
      end
      if (acc) begin
         exp_q.push_back(ref_add(a, b));
         tag_q.push_back(tg);
      end
   endtask

   task automatic send(input logic [31:0] a, input logic [31:0] b, input string tg);
      bit acc;
      if ($urandom % 5 == 0) step(1'b0, 32'h0, 32'h0, tg, ($urandom % 4) != 0, acc);
      do step(1'b1, a, b, tg, ($urandom % 4) != 0, acc); while (!acc);
   endtask

   task automatic drain();
      bit acc;
      while (exp_q.size() != 0) step(1'b0, 32'h0, 32'h0, "R9", 1'b1, acc);
      step(1'b0, 32'h0, 32'h0, "R9", 1'b1, acc);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   function automatic logic [31:0] rnd_norm();
      return {1'($urandom), 8'(1 + $urandom % 254), 23'($urandom)};
   endfunction

   function automatic logic [31:0] rnd_near(input logic [31:0] x);
      int e;
      e = int'(x[30:23]) + int'($urandom % 5) - 2;
      if (e < 1) e = 1;
      if (e > 254) e = 254;
      return {(($urandom % 4) != 0) ? ~x[31] : x[31], e[7:0], 23'($urandom)};
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual run still going expected completed");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      bit acc;
      // R10: reset state
      repeat (3) @(negedge clk);
      check_bit("R10", out_valid, 1'b0, "out_valid in reset");
      check_bit("R10", in_ready, 1'b1, "in_ready in reset");
      rst_n = 1'b1;

      // R1: plain sums
      send(32'h3F800000, 32'h3F800000, "R1");
      send(32'h3FC00000, 32'h40400000, "R1");
      send(32'hC0490FDB, 32'h3E800000, "R1");
      // R4: significand carry and rounding carry
      send(32'h3FC00000, 32'h3FC00000, "R4");
      send(32'h3FFFFFFF, 32'h3FFFFFFF, "R4");
      send(32'h3FFFFFFF, 32'h33800000, "R4");
      // R2: alignment, ties and sticky
      send(32'h3F800000, 32'h33000000, "R2");
      send(32'h3F800000, 32'h33800000, "R2");
      send(32'h3F800001, 32'h33800000, "R2");
      send(32'h4B000000, 32'h3F000000, "R2");
      send(32'h3F800000, 32'h00800000, "R2");
      send(32'h3F800000, 32'hB3000000, "R2");
      send(32'h3F800000, 32'hB3800001, "R2");
      // R3: cancellation
      send(32'h3F800000, 32'hBF800000, "R3");
      send(32'h3F800001, 32'hBF800000, "R3");
      send(32'hC1200000, 32'h41100000, "R3");
      send(32'h3F800000, 32'hC0000000, "R3");
      // R5: zeros and flushed subnormals
      send(32'h00000000, 32'h3F800000, "R5");
      send(32'hBF400000, 32'h80000000, "R5");
      send(32'h80000000, 32'h80000000, "R5");
      send(32'h00000000, 32'h80000000, "R5");
      send(32'h00400000, 32'h3F800000, "R5");
      send(32'h00400000, 32'h80000001, "R5");
      // R6: overflow
      send(32'h7F7FFFFF, 32'h7F7FFFFF, "R6");
      send(32'hFF7FFFFF, 32'hFF7FFFFF, "R6");
      send(32'h7F7FFFFF, 32'h73000000, "R6");
      // R7: underflow
      send(32'h00800001, 32'h80800000, "R7");
      send(32'h80800001, 32'h00800000, "R7");
      send(32'h01000000, 32'h80800000, "R7");
      // R8: specials
      send(32'h7FC00000, 32'h3F800000, "R8");
      send(32'h7F800001, 32'h00000000, "R8");
      send(32'h7F800000, 32'hFF800000, "R8");
      send(32'h7F800000, 32'h3F800000, "R8");
      send(32'hFF800000, 32'hFF800000, "R8");
      send(32'h7F800000, 32'h7F7FFFFF, "R8");
      drain();

      // R9: long stall then release
      step(1'b1, 32'h40000000, 32'h40000000, "R9", 1'b0, acc);
      for (int i = 0; i < 4; i++) step(1'b1, 32'h3F800000, 32'h3F800000, "R9", 1'b0, acc);
      drain();

      // R1/R3: random operands, wide and close exponents
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a;
         a = rnd_norm();
         if (i % 2 == 0) send(a, rnd_norm(), "R1");
         else            send(a, rnd_near(a), "R3");
      end
      // R7: random operands near the bottom of the range
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a;
         a = {1'($urandom), 8'(1 + $urandom % 3), 23'($urandom)};
         send(a, rnd_near(a), "R7");
      end
      drain();
      finish_run();
   end

endmodule